// File: doc/BRIEF.md
# Down-Counting Interval Timer Channel

This block is a single timer channel that counts down once per microsecond tick. A separate tick generator supplies the tick as a one-cycle enable. Software arms the channel by writing one word to the trigger register. That word carries an enable bit, a periodic-mode bit and a start count. The count is loaded as n-1 so that the channel expires after n ticks.

On expiry the channel sets a pending flag. The flag drives an active-high, level-sensitive interrupt line toward the interrupt controller. In one-shot mode the channel then disarms itself. In periodic mode it reloads the programmed count and keeps running, so a count of 999 gives one expiry every 1000 ticks.

The pending flag is cleared only by a write to a separate control register that has bit 30 set. Reading the control register returns the remaining count and the pending flag. The bus interface is a simple single-cycle write strobe with a combinational read.

Top module: `tmr_channel`

## Requirements
- R1: The trigger register is at byte address 0x0. Bit 31 is the enable, bit 30 selects periodic mode, and bits 28:0 hold the start count (maximum 0x1FFFFFFF). Bit 29 is ignored on write. A read of the trigger register returns enable in bit 31, periodic in bit 30, zero in bit 29 and the programmed count in bits 28:0. After reset the trigger register reads 0.
- R2: The remaining count changes only in cycles where tick_en is high and the channel is enabled. It drops by one per such cycle.
- R3: Expiry happens on the tick at which the remaining count is zero. A start count of v therefore expires on tick v+1, and a start count of 0 expires on the first tick.
- R4: In one-shot mode (bit 30 = 0) the enable bit clears on expiry. The count then stays at 0 through later ticks.
- R5: In periodic mode, expiry reloads the programmed count and counting continues with the enable bit still set.
- R6: Writing 0 to the trigger register stops the channel. The count reads 0 and no expiry occurs on later ticks.
- R7: A trigger write restarts counting from the written count. The write takes priority over a tick in the same cycle, and a pending interrupt remains set across the write.
- R8: irq is high while an interrupt is pending. It stays high until a write to byte address 0x4 with bit 30 set clears it. A control write without bit 30 has no effect on it.
- R9: If a clear write and an expiry fall in the same cycle, the interrupt remains pending.
- R10: Reading byte address 0x4 returns the remaining count in bits 28:0, the pending flag in bit 30 and zero elsewhere. After reset it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle microsecond tick enable |
| bus_wr | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 3 | Byte address: 0x0 trigger, 0x4 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Active-high level interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands in the very cycle the count expires. Hitting it needs the tick, the zero count and the control write to coincide on one clock edge. The bench arranges this by arming a periodic channel with a start count of 0, so every tick expires. It then issues the clear write with tick_en held high in the same cycle. A related corner case is a trigger write that coincides with a tick. The bench reaches it the same way, by driving both in one cycle and then checking that the count shows the written value rather than a decremented one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int EN_BIT   = 31;
  localparam int PER_BIT  = 30;
  localparam int PEND_BIT = 30;
  localparam int CLR_BIT  = 30;

  // Trigger readback word: enable, periodic mode, programmed count.
  function automatic logic [DATA_W-1:0] pack_trig(input logic en, input logic per,
                                                  input logic [DATA_W-1:0] cnt);
    logic [DATA_W-1:0] w;
    w = cnt;
    w[EN_BIT]  = en;
    w[PER_BIT] = per;
    return w;
  endfunction

  // Control readback word: pending flag above the remaining count.
  function automatic logic [DATA_W-1:0] pack_ctrl(input logic pend,
                                                  input logic [DATA_W-1:0] cnt);
    logic [DATA_W-1:0] w;
    w = cnt;
    w[PEND_BIT] = pend;
    return w;
  endfunction
endpackage

// File: rtl/tmr_trig_reg.sv
module tmr_trig_reg #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic             load_per,
  input  logic [CNT_W-1:0] load_val,
  input  logic             expire,
  output logic             run,
  output logic             periodic,
  output logic [CNT_W-1:0] reload
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      periodic <= 1'b0;
      reload   <= '0;
    end else if (load) begin
      run      <= load_en;
      periodic <= load_per;
      reload   <= load_val;
    end else if (expire && !periodic) begin
      run      <= 1'b0;
    end
  end

  // R4: one-shot expiry disarms the channel
  p_oneshot_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic && !load) |=> !run);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             periodic,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic per,
                                                  input logic [CNT_W-1:0] rl);
    if (cur == '0) return per ? rl : '0;
    return cur - CNT_W'(1);
  endfunction

  logic step;
  assign step   = tick_en && run && !load;
  assign expire = step && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= next_count(count, periodic, reload);
  end

  // R2: count holds without a tick or a load
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(count));
  // R2: count drops by one per enabled tick
  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && run && !load && count != '0) |=> (count == $past(count) - CNT_W'(1)));
  // R5: periodic expiry reloads the programmed count
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (count == $past(reload)));
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  // R3: expiry raises the pending flag
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n) set |=> pend);
  // R8: pending holds until cleared
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) (pend && !clr) |=> pend);
  // R9: set beats a same-cycle clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n) (set && clr) |=> pend);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4);

  logic             sel_trig, sel_ctrl, wr_trig, clr_req;
  logic             run, periodic, expire, pend;
  logic [CNT_W-1:0] reload, count, load_val;
  logic             unused_wbits;

  assign sel_trig = (bus_addr == TRIG_ADDR);
  assign sel_ctrl = (bus_addr == CTRL_ADDR);
  assign wr_trig  = bus_wr && sel_trig;
  assign clr_req  = bus_wr && sel_ctrl && bus_wdata[CLR_BIT];
  assign load_val = bus_wdata[CNT_W-1:0];
  assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];

  tmr_trig_reg #(.CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .load(wr_trig),
    .load_en(bus_wdata[EN_BIT]), .load_per(bus_wdata[PER_BIT]), .load_val(load_val),
    .expire(expire), .run(run), .periodic(periodic), .reload(reload)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .periodic(periodic),
    .load(wr_trig), .load_val(load_val), .reload(reload),
    .count(count), .expire(expire)
  );

  tmr_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(expire), .clr(clr_req), .pend(pend)
  );

  assign irq = pend;

  always_comb begin
    bus_rdata = '0;
    if (sel_trig)      bus_rdata = pack_trig(run, periodic, DATA_W'(reload));
    else if (sel_ctrl) bus_rdata = pack_ctrl(pend, DATA_W'(count));
  end

  // R6: a stopped channel never expires
  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire);
  // R7: a trigger write loads the written count
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig |=> (count == $past(load_val)));
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tmr_channel dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
                   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                   .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic tk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'h0, v); check("R1 trigger reset", v, 32'h0);
    rd(3'h4, v); check("R10 control reset", v, 32'h0);
    check("R8 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(3'h0, 32'h8000_0004, 1'b0);
    rd(3'h4, v); check("R10 count after load", v, 32'h4);
    for (int i = 3; i >= 0; i--) begin
      tick(1);
      rd(3'h4, v); check("R2 count down", v, 32'(i));
    end
    check("R3 no irq before tick v+1", {31'b0, irq}, 32'h0);
    tick(1);
    check("R3 irq on tick v+1", {31'b0, irq}, 32'h1);
    rd(3'h0, v); check("R4 enable cleared", v, 32'h0000_0004);
    tick(3);
    rd(3'h4, v); check("R4 count held at 0, R10 pending bit", v, 32'h4000_0000);
  endtask

  task automatic t_clear();
    wr(3'h4, 32'h0000_0001, 1'b0);
    check("R8 other bits no clear", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000, 1'b0);
    check("R8 clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_notick();
    logic [31:0] v;
    wr(3'h0, 32'h8000_0007, 1'b0);
    repeat (5) @(negedge clk);
    rd(3'h4, v); check("R2 no tick no change", v, 32'h7);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(3'h0, 32'hC000_0002, 1'b0);
    for (int k = 0; k < 2; k++) begin
      tick(1); rd(3'h4, v); check("R5 periodic step", v, 32'h1);
      tick(1); rd(3'h4, v); check("R5 periodic step", v, 32'h0);
      check("R5 no early irq", {31'b0, irq}, 32'h0);
      tick(1); rd(3'h4, v); check("R5 reload with pending", v, 32'h4000_0002);
      rd(3'h0, v); check("R5 still enabled", v, 32'hC000_0002);
      wr(3'h4, 32'h4000_0000, 1'b0);
    end
  endtask

  task automatic t_min();
    wr(3'h0, 32'h8000_0000, 1'b0);
    check("R3 load 0 no irq yet", {31'b0, irq}, 32'h0);
    tick(1);
    check("R3 load 0 expires on first tick", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(3'h0, 32'h8000_0009, 1'b0);
    check("R7 pending kept across write", {31'b0, irq}, 32'h1);
    tick(3);
    rd(3'h4, v); check("R7 mid count", v, 32'h4000_0006);
    wr(3'h0, 32'h8000_0003, 1'b1);
    rd(3'h4, v); check("R7 write beats tick", v, 32'h4000_0003);
    wr(3'h4, 32'h4000_0000, 1'b0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(3'h0, 32'h8000_0005, 1'b0);
    tick(2);
    rd(3'h4, v); check("R2 two ticks", v, 32'h3);
    wr(3'h0, 32'h0, 1'b0);
    tick(10);
    rd(3'h4, v); check("R6 stopped count", v, 32'h0);
    check("R6 no irq", {31'b0, irq}, 32'h0);
    rd(3'h0, v); check("R6 trigger cleared", v, 32'h0);
  endtask

  task automatic t_max();
    logic [31:0] v;
    wr(3'h0, 32'hFFFF_FFFF, 1'b0);
    rd(3'h0, v); check("R1 bit 29 ignored", v, 32'hDFFF_FFFF);
    rd(3'h4, v); check("R1 max count", v, 32'h1FFF_FFFF);
    tick(1);
    rd(3'h4, v); check("R2 max minus one", v, 32'h1FFF_FFFE);
    wr(3'h0, 32'h0, 1'b0);
  endtask

  task automatic t_collide();
    wr(3'h0, 32'hC000_0000, 1'b0);
    tick(1);
    check("R5 periodic min expiry", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000, 1'b1);
    check("R9 expiry beats clear", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000, 1'b0);
    check("R8 clear without tick", {31'b0, irq}, 32'h0);
    wr(3'h0, 32'h0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_clear();
    t_notick();
    t_periodic();
    t_min();
    t_restart();
    t_stop();
    t_max();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule